// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sequences the entry into a non-maskable or a maskable interrupt for an 8-bit processor core. It owns the program counter, the stack pointer and the status flags. When a request is taken it saves the return address and the status byte on a downward-growing stack in page one. It then sets interrupt-disable and fetches the new program counter from the vector that belongs to the request. Decimal mode is not acted on: the D flag is stored and reported, but nothing else in the block uses it.

The same engine also serves single-byte stack pushes and pulls issued by the surrounding core. It reaches memory over one byte-wide port with a valid/ready handshake. Once `mem_valid` is high, the address, direction and write data stay frozen until `mem_ready` is seen high at a clock edge. Stack operations come in on a valid/ready port: the requester keeps `op_valid` and its data stable until it sees `op_ready`. Pulled data appears on `pull_data` with a one-cycle `pull_valid` strobe, which has no back-pressure. The PC, SP and status load strobes are plain control pins and act only while `busy` is low.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset `pc` is 0x0000, `sp` is 0xFD, `p_out` is 0x34 (only I set), and `busy` is low.
- R2: Interrupt entry writes PC[15:8] to 0x0100+S, then PC[7:0] to 0x0100+S-1, then the status byte to 0x0100+S-2. S ends at S-3, wrapping modulo 256.
- R3: The status byte pushed on entry is {N,V,1,0,D,I,Z,C} (bit 7 down to bit 0): the break bit (bit 4) is 0 and bit 5 is 1.
- R4: After entry I is 1, and N, V, D, Z and C keep their previous values.
- R5: After the pushes the block reads the low byte and then the high byte of the vector. The vector is at 0xFFFA/0xFFFB for NMI and at 0xFFFE/0xFFFF for IRQ. The two bytes form the new `pc`.
- R6: With `mem_ready` held high, entry takes 7 cycles: the acknowledge cycle plus 6 cycles with `busy` high. Each stalled memory cycle adds one cycle.
- R7: NMI is taken whatever the value of I and wins over IRQ. IRQ is ignored while I is 1, and is then neither acknowledged nor allowed to start any bus activity.
- R8: A stack push writes `op_wdata` at 0x0100+S and then decrements S, so 0x00 becomes 0xFF.
- R9: A stack pull increments S first and then reads 0x0100+S. The byte appears on `pull_data` with `pull_valid` high in the cycle after the memory handshake.
- R10: A status load unpacks N, V, D, I, Z and C from bits 7, 6, 3, 2, 1 and 0 and ignores bits 5 and 4. `p_out` reports {N,V,1,1,D,I,Z,C}.
- R11: PC, SP and status loads requested while `busy` is high have no effect.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged.
- R13: `op_ready` is high only when the block is idle and is not accepting an interrupt in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable interrupt request, held until acknowledged |
| irq_req | input | 1 | Maskable interrupt request, held until acknowledged |
| ack_nmi | output | 1 | NMI accepted in this cycle |
| ack_irq | output | 1 | IRQ accepted in this cycle |
| busy | output | 1 | A sequence is in progress |
| op_valid | input | 1 | Stack operation request |
| op_ready | output | 1 | Stack operation accepted when high together with op_valid |
| op_pull | input | 1 | 1 = pull, 0 = push |
| op_wdata | input | 8 | Byte to push |
| pull_valid | output | 1 | Pulled byte is on pull_data |
| pull_data | output | 8 | Pulled byte |
| mem_valid | output | 1 | Memory access request |
| mem_ready | input | 1 | Memory accepts the access |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the handshake cycle |
| pc_ld | input | 1 | Load pc from pc_in |
| pc_in | input | 16 | New program counter |
| pc | output | 16 | Program counter |
| sp_ld | input | 1 | Load sp from sp_in |
| sp_in | input | 8 | New stack pointer |
| sp | output | 8 | Stack pointer |
| p_ld | input | 1 | Load the flags from p_in |
| p_in | input | 8 | Status byte to unpack |
| p_out | output | 8 | Packed status byte |

## Verification
The assertions assume that a requester keeps `nmi_req` or `irq_req` high until it is acknowledged and then drops it. They also assume that `op_valid` is held stable until accepted, and that memory returns read data in the same cycle as `mem_ready`. The stimulus drives every request from the falling clock edge and releases it on the first falling edge after the acknowledge. Memory is modelled as a combinational responder whose ready line is either held high or stalls every third cycle. Loads are issued only while idle, apart from one run that drives them during an entry on purpose, to show they are ignored.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  localparam int AW = 16;
  localparam int DW = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_INT, S_PCH, S_PCL, S_PST, S_VLO, S_VHI, S_PUSH, S_PULL
  } seq_state_t;

  typedef struct packed {
    logic n;
    logic v;
    logic d;
    logic i;
    logic z;
    logic c;
  } flags_t;

  // Status byte layout: N V 1 B D I Z C
  function automatic logic [DW-1:0] pack_status(flags_t f, logic brk);
    return {f.n, f.v, 1'b1, brk, f.d, f.i, f.z, f.c};
  endfunction
endpackage

// File: rtl/irqseq_flags.sv
module irqseq_flags
  import irqseq_pkg::*;
#(
  parameter logic [DW-1:0] P_RST = 8'h34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] ld_byte,
  input  logic          set_i,
  output logic          flag_i,
  output logic [DW-1:0] p_sw,
  output logic [DW-1:0] p_int
);
  flags_t f;
  flags_t ld_f;
  flags_t rst_f;
  logic   unused_pad;

  assign ld_f       = '{n: ld_byte[7], v: ld_byte[6], d: ld_byte[3],
                        i: ld_byte[2], z: ld_byte[1], c: ld_byte[0]};
  assign rst_f      = '{n: P_RST[7], v: P_RST[6], d: P_RST[3],
                        i: P_RST[2], z: P_RST[1], c: P_RST[0]};
  assign unused_pad = ^ld_byte[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n)     f   <= rst_f;
    else if (set_i) f.i <= 1'b1;
    else if (ld)    f   <= ld_f;
  end

  assign flag_i = f.i;
  assign p_sw   = pack_status(f, 1'b1);
  assign p_int  = pack_status(f, 1'b0);

  a_r4_i_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_i);
  a_r4_d_kept: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> (p_sw[3] == $past(p_sw[3])) && (p_sw[7:6] == $past(p_sw[7:6])));
endmodule

// File: rtl/irqseq_sp.sv
module irqseq_sp
  import irqseq_pkg::*;
#(
  parameter logic [DW-1:0] SP_RST = 8'hFD
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  input  logic          inc,
  input  logic          dec,
  output logic [DW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sp <= SP_RST;
    else if (dec) sp <= sp - 8'd1;
    else if (inc) sp <= sp + 8'd1;
    else if (ld)  sp <= ld_val;
  end

  a_r8_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> sp == $past(sp) - 8'd1);
  a_r9_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> sp == $past(sp) + 8'd1);
endmodule

// File: rtl/irqseq_ctrl.sv
module irqseq_ctrl
  import irqseq_pkg::*;
#(
  parameter logic [AW-1:0] NMI_VEC    = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE,
  parameter logic [7:0]    STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] PC_RST     = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_req,
  input  logic          irq_req,
  input  logic          flag_i,
  input  logic [DW-1:0] sp,
  input  logic [DW-1:0] p_int,
  input  logic          op_valid,
  input  logic          op_pull,
  input  logic [DW-1:0] op_wdata,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  input  logic          pc_ld,
  input  logic [AW-1:0] pc_in,
  output logic          ack_nmi,
  output logic          ack_irq,
  output logic          op_ready,
  output logic          busy,
  output logic          mem_valid,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sp_inc,
  output logic          sp_dec,
  output logic          set_i,
  output logic [AW-1:0] pc,
  output logic          pull_valid,
  output logic [DW-1:0] pull_data
);
  seq_state_t    st, nxt;
  logic [AW-1:0] vec_q;
  logic [DW-1:0] push_q;
  logic [DW-1:0] lo_q;
  logic          idle, hs;

  assign idle     = (st == S_IDLE);
  assign ack_nmi  = idle && nmi_req;
  assign ack_irq  = idle && irq_req && !flag_i && !nmi_req;
  assign op_ready = idle && !ack_nmi && !ack_irq;
  assign busy     = !idle;
  assign hs       = mem_valid && mem_ready;
  assign sp_dec   = hs && mem_we;
  assign sp_inc   = hs && (st == S_PULL);
  assign set_i    = hs && (st == S_PST);

  // Bus outputs depend on state only, so they hold through a stall
  always_comb begin
    mem_valid = 1'b1;
    mem_we    = 1'b1;
    mem_addr  = {STACK_PAGE, sp};
    mem_wdata = '0;
    case (st)
      S_PCH:  mem_wdata = pc[AW-1:8];
      S_PCL:  mem_wdata = pc[7:0];
      S_PST:  mem_wdata = p_int;
      S_PUSH: mem_wdata = push_q;
      S_PULL: begin mem_we = 1'b0; mem_addr = {STACK_PAGE, 8'(sp + 8'd1)}; end
      S_VLO:  begin mem_we = 1'b0; mem_addr = vec_q; end
      S_VHI:  begin mem_we = 1'b0; mem_addr = AW'(vec_q + 1'b1); end
      default: begin mem_valid = 1'b0; mem_we = 1'b0; end
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE: if (ack_nmi || ack_irq) nxt = S_INT;
              else if (op_valid)      nxt = op_pull ? S_PULL : S_PUSH;
      S_INT:  nxt = S_PCH;
      S_PCH:  if (hs) nxt = S_PCL;
      S_PCL:  if (hs) nxt = S_PST;
      S_PST:  if (hs) nxt = S_VLO;
      S_VLO:  if (hs) nxt = S_VHI;
      S_VHI:  if (hs) nxt = S_IDLE;
      S_PUSH: if (hs) nxt = S_IDLE;
      S_PULL: if (hs) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      vec_q      <= NMI_VEC;
      push_q     <= '0;
      lo_q       <= '0;
      pc         <= PC_RST;
      pull_valid <= 1'b0;
      pull_data  <= '0;
    end else begin
      st         <= nxt;
      pull_valid <= hs && (st == S_PULL);
      if (ack_nmi)      vec_q <= NMI_VEC;
      else if (ack_irq) vec_q <= IRQ_VEC;
      if (op_valid && op_ready) push_q <= op_wdata;
      if (hs && st == S_VLO)    lo_q <= mem_rdata;
      if (hs && st == S_PULL)   pull_data <= mem_rdata;
      if (idle && pc_ld)             pc <= pc_in;
      else if (hs && st == S_VHI)    pc <= {mem_rdata, lo_q};
    end
  end

  a_r12_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
                              && $stable(mem_we) && $stable(mem_wdata));
  a_r2_writes_in_stack: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_we |-> mem_addr[AW-1:8] == STACK_PAGE);
  a_r3_pushed_status: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_PST |-> mem_wdata[5] && !mem_wdata[4]);
  a_r5_vec_high_odd: assert property (@(posedge clk) disable iff (!rst_n)
    st == S_VHI |-> mem_addr[0] && !mem_we);
  a_r6_ack_quiet_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_nmi || ack_irq) |=> busy && !mem_valid);
  a_r7_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_nmi, ack_irq}));
  a_r13_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> !busy && !mem_valid);
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irqseq_pkg::*;
#(
  parameter logic [AW-1:0] NMI_VEC    = 16'hFFFA,
  parameter logic [AW-1:0] IRQ_VEC    = 16'hFFFE,
  parameter logic [7:0]    STACK_PAGE = 8'h01,
  parameter logic [AW-1:0] PC_RST     = 16'h0000,
  parameter logic [DW-1:0] SP_RST     = 8'hFD,
  parameter logic [DW-1:0] P_RST      = 8'h34
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          nmi_req,
  input  logic          irq_req,
  output logic          ack_nmi,
  output logic          ack_irq,
  output logic          busy,
  input  logic          op_valid,
  output logic          op_ready,
  input  logic          op_pull,
  input  logic [DW-1:0] op_wdata,
  output logic          pull_valid,
  output logic [DW-1:0] pull_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          pc_ld,
  input  logic [AW-1:0] pc_in,
  output logic [AW-1:0] pc,
  input  logic          sp_ld,
  input  logic [DW-1:0] sp_in,
  output logic [DW-1:0] sp,
  input  logic          p_ld,
  input  logic [DW-1:0] p_in,
  output logic [DW-1:0] p_out
);
  logic          flag_i, set_i, sp_inc, sp_dec;
  logic [DW-1:0] p_int;

  irqseq_flags #(.P_RST(P_RST)) u_flags (
    .clk(clk), .rst_n(rst_n), .ld(p_ld && !busy), .ld_byte(p_in),
    .set_i(set_i), .flag_i(flag_i), .p_sw(p_out), .p_int(p_int)
  );

  irqseq_sp #(.SP_RST(SP_RST)) u_sp (
    .clk(clk), .rst_n(rst_n), .ld(sp_ld && !busy), .ld_val(sp_in),
    .inc(sp_inc), .dec(sp_dec), .sp(sp)
  );

  irqseq_ctrl #(
    .NMI_VEC(NMI_VEC), .IRQ_VEC(IRQ_VEC),
    .STACK_PAGE(STACK_PAGE), .PC_RST(PC_RST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
    .flag_i(flag_i), .sp(sp), .p_int(p_int),
    .op_valid(op_valid), .op_pull(op_pull), .op_wdata(op_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .pc_ld(pc_ld), .pc_in(pc_in),
    .ack_nmi(ack_nmi), .ack_irq(ack_irq), .op_ready(op_ready), .busy(busy),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .sp_inc(sp_inc), .sp_dec(sp_dec), .set_i(set_i),
    .pc(pc), .pull_valid(pull_valid), .pull_data(pull_data)
  );
endmodule

// File: tb/tb_irq_entry_seq.sv
`timescale 1ns/1ps
module tb_irq_entry_seq;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        nmi_req = 1'b0, irq_req = 1'b0;
  logic        ack_nmi, ack_irq, busy;
  logic        op_valid = 1'b0, op_pull = 1'b0;
  logic [7:0]  op_wdata = '0;
  logic        op_ready, pull_valid;
  logic [7:0]  pull_data;
  logic        mem_valid, mem_we;
  logic        mem_ready = 1'b1;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        pc_ld = 1'b0, sp_ld = 1'b0, p_ld = 1'b0;
  logic [15:0] pc_in = '0, pc;
  logic [7:0]  sp_in = '0, sp, p_in = '0, p_out;

  logic [7:0]  stk [0:255];
  logic [7:0]  vec [0:5];
  logic        stall = 1'b0;
  int          cyc = 0;
  int          total = 0, fails = 0;
  logic [24:0] expq [$];   // {we, addr, data}

  always #2 clk = ~clk;

  irq_entry_seq dut (.*);

  always_comb begin
    if (mem_addr[15:8] == 8'h01)  mem_rdata = stk[mem_addr[7:0]];
    else if (mem_addr >= 16'hFFFA) mem_rdata = vec[3'(mem_addr - 16'hFFFA)];
    else                           mem_rdata = 8'hEE;
  end

  always @(posedge clk) begin
    cyc       <= cyc + 1;
    mem_ready <= stall ? (cyc % 3 != 0) : 1'b1;
    if (rst_n && mem_valid && mem_ready && mem_we && mem_addr[15:8] == 8'h01)
      stk[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference transfer list, compared on every accepted bus cycle (R2 R5 R8 R9 R12)
  always @(negedge clk) begin
    if (rst_n && mem_valid && mem_ready) begin
      if (expq.size() == 0) chk(1'b0, "R12 unexpected transfer", {mem_we, mem_addr}, 0);
      else begin
        logic [24:0] e;
        e = expq.pop_front();
        chk(mem_we == e[24] && mem_addr == e[23:8] && (!e[24] || mem_wdata == e[7:0]),
            "R2/R5 transfer", {7'd0, mem_we, mem_addr, mem_wdata}, {7'd0, e});
      end
    end
  end

  task automatic load(input logic [15:0] a, input logic [7:0] s, input logic [7:0] p, input logic [7:0] pexp);
    @(negedge clk);
    pc_ld = 1; pc_in = a; sp_ld = 1; sp_in = s; p_ld = 1; p_in = p;
    @(negedge clk);
    pc_ld = 0; sp_ld = 0; p_ld = 0;
    chk(pc == a && sp == s, "R10 pc/sp load", {pc, sp}, {a, s});
    chk(p_out == pexp, "R10 status unpack/pack", p_out, pexp);
  endtask

  task automatic run_int(input bit nmi, input bit irq, input logic [15:0] pc0, input logic [7:0] sp0,
                         input logic [7:0] st_push, input logic [15:0] pc_new, input logic [7:0] p_after,
                         input bit disturb, input bit timed);
    logic [15:0] va;
    int n;
    va = nmi ? 16'hFFFA : 16'hFFFE;
    expq.push_back({1'b1, 8'h01, sp0, pc0[15:8]});
    expq.push_back({1'b1, 8'h01, 8'(sp0 - 8'd1), pc0[7:0]});
    expq.push_back({1'b1, 8'h01, 8'(sp0 - 8'd2), st_push});
    expq.push_back({1'b0, va, 8'h00});
    expq.push_back({1'b0, 16'(va + 16'd1), 8'h00});
    @(negedge clk);
    nmi_req = nmi; irq_req = irq;
    #1;
    chk(ack_nmi == nmi && ack_irq == (irq && !nmi), "R7 acknowledge select",
        {ack_nmi, ack_irq}, {nmi, irq && !nmi});
    @(negedge clk);
    nmi_req = 0; irq_req = 0;
    if (disturb) begin
      pc_ld = 1; pc_in = 16'h5555; sp_ld = 1; sp_in = 8'h10; p_ld = 1; p_in = 8'h00;
      chk(op_ready == 1'b0, "R13 no ready while busy", op_ready, 0);
    end
    n = 1;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
      pc_ld = 0; sp_ld = 0; p_ld = 0;
    end
    if (timed) chk(n == 7, "R6 entry length", n, 7);
    else       chk(n > 7,  "R6 stalled entry longer", n, 8);
    chk(pc == pc_new, "R5 vector into pc", pc, pc_new);
    chk(sp == 8'(sp0 - 8'd3), "R2 sp after entry", sp, 8'(sp0 - 8'd3));
    chk(p_out == p_after, "R4 flags after entry", p_out, p_after);
    chk(expq.size() == 0, "R2 all entry transfers seen", expq.size(), 0);
  endtask

  task automatic stack_op(input bit pull, input logic [7:0] d, input logic [15:0] a,
                          input logic [7:0] sp_exp, input logic [7:0] d_exp);
    bit got;
    logic [7:0] gd;
    got = 0; gd = '0;
    expq.push_back({~pull, a, d});
    @(negedge clk);
    op_valid = 1; op_pull = pull; op_wdata = d;
    #1;
    chk(op_ready == 1'b1, "R13 ready when idle", op_ready, 1);
    @(negedge clk);
    op_valid = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (pull_valid) begin got = 1; gd = pull_data; end
      if (!busy) break;
    end
    if (pull) begin
      chk(got && gd == d_exp, "R9 pulled byte", {got, gd}, {1'b1, d_exp});
      chk(sp == sp_exp, "R9 sp after pull", sp, sp_exp);
    end else
      chk(sp == sp_exp, "R8 sp after push", sp, sp_exp);
    chk(expq.size() == 0, "R8 stack transfer seen", expq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) stk[k] = 8'h00;
    vec[0] = 8'h00; vec[1] = 8'h80; vec[2] = 8'h11;
    vec[3] = 8'h22; vec[4] = 8'h56; vec[5] = 8'hC0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(pc == 16'h0000 && sp == 8'hFD, "R1 reset pc/sp", {pc, sp}, {16'h0000, 8'hFD});
    chk(p_out == 8'h34 && !busy, "R1 reset status", {busy, p_out}, 9'h034);

    // NMI with I set: taken anyway (R7), status pushed with B=0 (R3)
    load(16'h1234, 8'hFD, 8'hC7, 8'hF7);
    run_int(1, 0, 16'h1234, 8'hFD, 8'hE7, 16'h8000, 8'hF7, 0, 1);

    // R7 IRQ ignored while I is set
    @(negedge clk);
    irq_req = 1;
    for (int k = 0; k < 5; k++) begin
      #1;
      chk(!ack_irq && !busy && !mem_valid, "R7 masked irq ignored", {ack_irq, busy, mem_valid}, 0);
      @(negedge clk);
    end
    irq_req = 0;
    chk(pc == 16'h8000 && sp == 8'hFA, "R7 state untouched by masked irq", {pc, sp}, {16'h8000, 8'hFA});

    // IRQ with D set and stalls; B in p_in ignored (R10); stack wraps (R2, R12)
    load(16'hABCD, 8'h02, 8'h18, 8'h38);
    stall = 1;
    run_int(0, 1, 16'hABCD, 8'h02, 8'h28, 16'hC056, 8'h3C, 0, 0);
    stall = 0;
    repeat (2) @(negedge clk);

    // NMI and IRQ together, loads driven while busy must be ignored (R7, R11)
    load(16'h0042, 8'hFD, 8'h00, 8'h30);
    run_int(1, 1, 16'h0042, 8'hFD, 8'h20, 16'h8000, 8'h34, 1, 1);
    chk(sp != 8'h10 && pc != 16'h5555, "R11 busy loads ignored", {pc, sp}, {16'h8000, 8'hFA});

    // Plain push at S=0 then pull back (R8, R9)
    load(16'h0000, 8'h00, 8'h04, 8'h34);
    stack_op(0, 8'hA5, 16'h0100, 8'hFF, 8'h00);
    stack_op(1, 8'h00, 16'h0100, 8'h00, 8'hA5);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule